// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block forms the status byte that a microcontroller sees when it reads a nonvolatile memory while an embedded program or erase algorithm is running, or just after an EEPROM data write. A small set of live signals from the algorithm and the bus is folded into one word. These signals are a busy level, the target kind (flash or EEPROM), bit 7 of the last byte written, a failure pulse, an erase-window-closed level and a status read strobe. Software polls that word to tell when the operation has finished and whether it failed.

Bit 7 carries data polling and bit 6 is a toggle bit, for both target kinds. A flash target also reports a sticky error flag on bit 5 and an erase-timeout flag on bit 3. An EEPROM target guarantees only bits 7 and 6. Every bit without a guaranteed meaning is driven to 0, so reads are deterministic. The word may be read as often as needed. The output is combinational from the registered flags and the current inputs. The reset is asserted asynchronously and released in step with the clock.

Top module: `pe_status_word`

## Requirements
- R1: After reset is released, with busy low and written bit 7 low, the status word reads 0x00. The toggle bit, the error flag and the timeout flag all start at 0.
- R2: Bit 7 reads the complement of the written bit 7 while busy is high, and its true value while busy is low. This holds for both targets.
- R3: On each cycle where the read strobe and busy are both high, the read returns the current bit 6, and bit 6 then inverts at that clock edge. Two back-to-back strobed reads while busy therefore differ in bit 6.
- R4: Bit 6 keeps its value in any cycle where busy is low or the read strobe is low.
- R5: The error flag is set by a failure pulse and stays set until the clear command. When a failure pulse and a clear arrive in the same cycle, the set wins. The flag appears on bit 5 only for a flash target.
- R6: The timeout flag is set when the erase window closes while busy is high, and clears in the cycle after busy is seen low. It appears on bit 3 only for a flash target.
- R7: For an EEPROM target (target input = 0), bits 5 to 0 read 0. For a flash target (target input = 1), bits 4, 2, 1 and 0 read 0. Bits at index 8 and above, when present, read 0.
- R8: Changing the target input changes only which flags are shown. Stored error, timeout and toggle state persist through a target change and reappear when flash is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Embedded operation in progress |
| tgt_flash_i | input | 1 | 1 = flash target, 0 = EEPROM target |
| wr_d7_i | input | 1 | Bit 7 of the last data written |
| fail_i | input | 1 | Failure pulse from the algorithm |
| clr_err_i | input | 1 | Reset command, clears the error flag |
| win_closed_i | input | 1 | Erase acceptance window has closed |
| rd_stb_i | input | 1 | Status read strobe |
| status_o | output | DATA_W | Status word |

## Verification
The bench builds the block with its default values: an 8-bit word and a toggle bit that starts at 0. With these values the reference model compares every bit of the word on every clock. Strobed reads are mixed with idle cycles and with the end of busy, so each inversion and each hold of the toggle is checked against the model. Sequences exercise the set/clear collision on the error flag, the end of busy clearing the timeout flag, and target changes while flags are set.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  localparam int unsigned POLL_POS = 7;
  localparam int unsigned TOG_POS  = 6;
  localparam int unsigned ERR_POS  = 5;
  localparam int unsigned TMO_POS  = 3;
  localparam int unsigned MIN_W    = 8;

  typedef enum logic {
    TGT_EEPROM = 1'b0,
    TGT_FLASH  = 1'b1
  } tgt_e;
endpackage

// File: rtl/pe_poll_toggle.sv
module pe_poll_toggle #(
  parameter logic TOG_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_stb_i,
  input  logic wr_d7_i,
  output logic poll_o,
  output logic tog_o
);
  logic tog_q, tog_d, tog_en;

  always_comb begin
    tog_en = busy_i & rd_stb_i;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= TOG_INIT;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  always_comb begin
    poll_o = busy_i ? ~wr_d7_i : wr_d7_i;
    tog_o  = tog_q;
  end

  AST_TOG_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_stb_i) |=> (tog_o != $past(tog_o))); // R3
  AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i || !rd_stb_i) |=> $stable(tog_o)); // R4
endmodule

// File: rtl/pe_flag_track.sv
module pe_flag_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic fail_i,
  input  logic clr_i,
  input  logic win_closed_i,
  output logic err_o,
  output logic tmo_o
);
  logic err_q, err_d;
  logic tmo_q, tmo_d;

  always_comb begin
    err_d = err_q;
    if (fail_i) begin
      err_d = 1'b1;
    end else if (clr_i) begin
      err_d = 1'b0;
    end
    tmo_d = tmo_q;
    if (!busy_i) begin
      tmo_d = 1'b0;
    end else if (win_closed_i) begin
      tmo_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      err_q <= err_d;
      tmo_q <= tmo_d;
    end
  end

  assign err_o = err_q;
  assign tmo_o = tmo_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o); // R5
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> err_o); // R5
  AST_TMO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !tmo_o); // R6
endmodule

// File: rtl/pe_word_pack.sv
module pe_word_pack
  import pe_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              tgt_flash_i,
  input  logic              poll_i,
  input  logic              tog_i,
  input  logic              err_i,
  input  logic              tmo_i,
  output logic [DATA_W-1:0] status_o
);
  tgt_e tgt;

  always_comb begin
    tgt = tgt_e'(tgt_flash_i);
    status_o           = '0;
    status_o[POLL_POS] = poll_i;
    status_o[TOG_POS]  = tog_i;
    if (tgt == TGT_FLASH) begin
      status_o[ERR_POS] = err_i;
      status_o[TMO_POS] = tmo_i;
    end
  end
endmodule

// File: rtl/pe_status_word.sv
module pe_status_word
  import pe_status_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter logic        TOG_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              tgt_flash_i,
  input  logic              wr_d7_i,
  input  logic              fail_i,
  input  logic              clr_err_i,
  input  logic              win_closed_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] status_o
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_int;
  logic              poll, tog, err, tmo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[SYNC_N-1];

  pe_poll_toggle #(.TOG_INIT(TOG_INIT)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .busy_i  (busy_i),
    .rd_stb_i(rd_stb_i),
    .wr_d7_i (wr_d7_i),
    .poll_o  (poll),
    .tog_o   (tog)
  );

  pe_flag_track u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .busy_i      (busy_i),
    .fail_i      (fail_i),
    .clr_i       (clr_err_i),
    .win_closed_i(win_closed_i),
    .err_o       (err),
    .tmo_o       (tmo)
  );

  pe_word_pack #(.DATA_W(DATA_W)) u_pack (
    .tgt_flash_i(tgt_flash_i),
    .poll_i     (poll),
    .tog_i      (tog),
    .err_i      (err),
    .tmo_i      (tmo),
    .status_o   (status_o)
  );

  AST_POLL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    busy_i |-> (status_o[POLL_POS] != wr_d7_i)); // R2
  AST_POLL_DONE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !busy_i |-> (status_o[POLL_POS] == wr_d7_i)); // R2
  AST_EE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !tgt_flash_i |-> (status_o[5:0] == 6'd0)); // R7
  AST_FLASH_SPARE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    tgt_flash_i |-> (status_o[4] == 1'b0 && status_o[2:0] == 3'd0)); // R7
endmodule

// File: tb/pe_status_word_tb.sv
module pe_status_word_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic busy, tgt, d7, fail, clr, win, rd;
  logic [DW-1:0] status;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_tog = 0, m_err = 0, m_tmo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_status_word #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .tgt_flash_i(tgt),
    .wr_d7_i(d7), .fail_i(fail), .clr_err_i(clr), .win_closed_i(win),
    .rd_stb_i(rd), .status_o(status)
  );

  function automatic logic [DW-1:0] model_word();
    logic [DW-1:0] w;
    w = '0;
    w[7] = busy ? ~d7 : d7;
    w[6] = m_tog[0];
    if (tgt) begin
      w[5] = m_err[0];
      w[3] = m_tmo[0];
    end
    return w;
  endfunction

  task automatic step(input string tag, input logic b, input logic t,
                      input logic dd, input logic f, input logic c,
                      input logic w, input logic r);
    logic [DW-1:0] exp;
    @(negedge clk);
    busy = b; tgt = t; d7 = dd; fail = f; clr = c; win = w; rd = r;
    #1;
    exp = model_word();
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status=%02h expected=%02h", tag, status, exp);
    end
    if (b && r) m_tog = m_tog ^ 1;
    if (f) m_err = 1; else if (c) m_err = 0;
    if (!b) m_tmo = 0; else if (w) m_tmo = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    busy = 0; tgt = 0; d7 = 0; fail = 0; clr = 0; win = 0; rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 1, 0, 0, 0, 0, 0);
    // R2 polling bit in both targets
    step("R2", 1, 1, 1, 0, 0, 0, 0);
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 1, 0, 0, 0, 0);
    // R3 toggle on strobed reads while busy
    for (int i = 0; i < 5; i++) step("R3", 1, 1, 1, 0, 0, 0, 1);
    // R4 toggle holds without strobe or busy
    step("R4", 1, 1, 1, 0, 0, 0, 0);
    step("R4", 0, 1, 1, 0, 0, 0, 1);
    step("R4", 0, 0, 1, 0, 0, 0, 1);
    step("R4", 0, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 0, 1);
    step("R3", 1, 0, 0, 0, 0, 0, 1);
    // R5 error flag: set, sticky, clear, collision
    step("R5", 1, 1, 0, 1, 0, 0, 1);
    step("R5", 1, 1, 0, 0, 0, 0, 0);
    step("R5", 0, 1, 0, 0, 0, 0, 0);
    step("R5", 0, 1, 0, 0, 1, 0, 0);
    step("R5", 0, 1, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 0, 1, 1, 0, 0);
    step("R5", 1, 1, 0, 0, 0, 0, 0);
    // R8 target change keeps stored flags
    step("R8", 1, 0, 1, 0, 0, 1, 1);
    step("R8", 1, 0, 1, 0, 0, 0, 0);
    step("R8", 1, 1, 1, 0, 0, 0, 0);
    // R6 timeout flag set while busy, cleared after busy drops
    step("R6", 1, 1, 1, 0, 0, 0, 1);
    step("R6", 0, 1, 1, 0, 0, 0, 0);
    step("R6", 0, 1, 1, 0, 0, 1, 0);
    step("R6", 0, 1, 1, 0, 0, 0, 0);
    step("R6", 1, 1, 0, 0, 0, 1, 0);
    step("R6", 1, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 0, 0, 1, 0, 0);
    // R7 spare bits with every flag set
    step("R7", 1, 1, 0, 1, 0, 1, 1);
    step("R7", 1, 0, 0, 0, 0, 1, 0);
    step("R7", 1, 1, 1, 0, 0, 0, 0);
    // mixed pattern
    for (int i = 0; i < 40; i++)
      step("R3", (i % 7) != 0, (i % 3) == 0, i[2], (i % 11) == 5,
           (i % 13) == 2, (i % 5) == 1, i[0]);
    step("R2", 0, 1, 1, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule